// File: doc/BRIEF.md
# UART Transmit Holding Buffer

This block takes characters from a bus-side byte write port, keeps them in a small FIFO, and passes them one at a time to a serial transmit shifter. A ready flag tells the bus master when another character may be written. The flag drops on every accepted write. It rises again only when the shifter takes a character out of the buffer. A write made while the flag is low, or while the transmitter is disabled, is discarded without any trace.

The shifter is included so that the handshake can be checked end to end. It sends a standard 8N1 frame paced by an external bit-clock enable. The bus master writes only while `ready_o` is high. The shifter loads a character as soon as it is idle, the buffer holds a character and the transmitter is enabled. Clearing the enable lets a frame already in progress finish, and it blocks the next load.

Top module: `uart_txb_top`

## Requirements
- R1: After reset `ready_o` is 1, `load_o` is 0, `shift_empty_o` is 1 and `txd_o` is 1.
- R2: A write (`wr_en_i`=1) is accepted only when `ready_o`=1 and `tx_en_i`=1. An accepted write makes `ready_o` 0 from the next cycle.
- R3: A write while `ready_o`=0 or `tx_en_i`=0 is dropped. Its data is never loaded into the shifter.
- R4: `load_o` is 1 in a cycle exactly when the shifter is empty, the buffer holds a character and `tx_en_i`=1. `load_data_o` then carries the oldest buffered character.
- R5: A load makes `ready_o` 1 from the next cycle.
- R6: From the cycle after a load, `txd_o` sends a start bit (0), then data bits 0 to 7 in that order, then a stop bit (1). Each bit moves on to the next at a cycle with `bit_tick_i`=1. `shift_empty_o` is 0 from the cycle after the load until the tick that ends the stop bit. While the shifter is empty, `txd_o` is 1.
- R7: Clearing `tx_en_i` does not cut short a frame in progress. No load happens while `tx_en_i`=0, and a buffered character stays in the buffer until the transmitter is enabled again.
- R8: The buffer (default depth 24) never holds more than its depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Byte write strobe from the bus |
| wr_data_i | input | 8 | Byte to write |
| tx_en_i | input | 1 | Transmitter enable |
| bit_tick_i | input | 1 | Bit-clock enable, one pulse per bit period |
| ready_o | output | 1 | Ready flag; a write is accepted while it is high |
| load_o | output | 1 | Strobe that loads a character into the shifter |
| load_data_o | output | 8 | Character being loaded |
| shift_empty_o | output | 1 | Shifter is idle |
| txd_o | output | 1 | Serial output |

## Verification
The assertions check the following on every cycle:
- how the ready flag reacts to an accepted write and to a load;
- that a load occurs only while the shifter is idle and enabled, and never while the flag is high;
- that a dropped write leaves the buffer unchanged;
- that the shifter turns busy after a load and the line stays high while it is idle;
- that the buffer never overflows.

Only the bench scenarios can show the following. A dropped character's value never reaches the line. Frames come out bit-exact with the LSB first. A character written during a frame waits for the frame to end. A character held while the transmitter is disabled goes out once it is enabled again.

// File: rtl/uart_txb_pkg.sv
package uart_txb_pkg;
  typedef enum logic [1:0] {
    SH_IDLE  = 2'd0,
    SH_START = 2'd1,
    SH_DATA  = 2'd2,
    SH_STOP  = 2'd3
  } sh_state_e;
endpackage

// File: rtl/uart_txb_fifo.sv
module uart_txb_fifo #(
  parameter int DEPTH  = 24,
  parameter int DATA_W = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  logic [DATA_W-1:0]          push_data_i,
  input  logic                       pop_i,
  output logic [DATA_W-1:0]          pop_data_o,
  output logic                       empty_o,
  output logic                       full_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]     cnt_q;
  logic              do_push, do_pop;

  assign empty_o    = (cnt_q == '0);
  assign full_o     = (cnt_q == CW'(DEPTH));
  assign count_o    = cnt_q;
  assign pop_data_o = mem_q[rd_ptr_q];
  assign do_push    = push_i && !full_o;
  assign do_pop     = pop_i && !empty_o;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/uart_txb_shifter.sv
module uart_txb_shifter
  import uart_txb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              tick_i,
  output logic              txd_o,
  output logic              empty_o
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  sh_state_e         state_q;
  logic [DATA_W-1:0] shreg_q;
  logic [CNT_W-1:0]  bit_cnt_q;

  assign empty_o = (state_q == SH_IDLE);

  always_comb begin
    case (state_q)
      SH_START: txd_o = 1'b0;
      SH_DATA:  txd_o = shreg_q[0];
      default:  txd_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= SH_IDLE;
      shreg_q   <= '0;
      bit_cnt_q <= '0;
    end else begin
      case (state_q)
        SH_IDLE: if (load_i) begin
          shreg_q   <= data_i;
          bit_cnt_q <= '0;
          state_q   <= SH_START;
        end
        SH_START: if (tick_i) state_q <= SH_DATA;
        SH_DATA: if (tick_i) begin
          shreg_q <= shreg_q >> 1;
          if (bit_cnt_q == CNT_W'(DATA_W - 1)) state_q <= SH_STOP;
          else bit_cnt_q <= bit_cnt_q + 1'b1;
        end
        SH_STOP: if (tick_i) state_q <= SH_IDLE;
        default: state_q <= SH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_txb_top.sv
module uart_txb_top #(
  parameter int DEPTH  = 24,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              tx_en_i,
  input  logic              bit_tick_i,
  output logic              ready_o,
  output logic              load_o,
  output logic [DATA_W-1:0] load_data_o,
  output logic              shift_empty_o,
  output logic              txd_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          ready_q, accept, buf_empty, buf_full;
  logic [CW-1:0] buf_count;

  assign accept  = wr_en_i && ready_q && tx_en_i && !buf_full;
  assign load_o  = !buf_empty && shift_empty_o && tx_en_i;
  assign ready_o = ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ready_q <= 1'b1;
    else if (load_o) ready_q <= 1'b1;
    else if (accept) ready_q <= 1'b0;
  end

  uart_txb_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (accept),
    .push_data_i (wr_data_i),
    .pop_i       (load_o),
    .pop_data_o  (load_data_o),
    .empty_o     (buf_empty),
    .full_o      (buf_full),
    .count_o     (buf_count)
  );

  uart_txb_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_o),
    .data_i  (load_data_o),
    .tick_i  (bit_tick_i),
    .txd_o   (txd_o),
    .empty_o (shift_empty_o)
  );
endmodule

// File: rtl/uart_txb_chk.sv
module uart_txb_chk #(
  parameter int DEPTH = 24,
  parameter int CW    = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic          tx_en_i,
  input logic          ready_o,
  input logic          load_o,
  input logic          shift_empty_o,
  input logic          txd_o,
  input logic [CW-1:0] buf_count
);
  AST_READY_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ready_o && tx_en_i) |=> !ready_o); // R2
  AST_DROP_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !(ready_o && tx_en_i) && !load_o) |=> $stable(buf_count)); // R3
  AST_LOAD_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> (shift_empty_o && tx_en_i && !ready_o)); // R4
  AST_READY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> ready_o); // R5
  AST_BUSY_AFTER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !shift_empty_o); // R6
  AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_empty_o |-> txd_o); // R6
  AST_NO_LOAD_DIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |-> !load_o); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_count <= CW'(DEPTH)); // R8
endmodule

bind uart_txb_top uart_txb_chk #(.DEPTH(DEPTH), .CW($clog2(DEPTH + 1))) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .tx_en_i       (tx_en_i),
  .ready_o       (ready_o),
  .load_o        (load_o),
  .shift_empty_o (shift_empty_o),
  .txd_o         (txd_o),
  .buf_count     (buf_count)
);

// File: tb/sim_uart_txb_top.sv
module sim_uart_txb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       tx_en_i = 1'b0;
  logic       bit_tick_i = 1'b0;
  logic       ready_o, load_o, shift_empty_o, txd_o;
  logic [7:0] load_data_o;

  int n_chk = 0, n_fail = 0, cyc = 0;

  // reference model state
  logic [7:0] m_q[$];
  logic       m_ready = 1'b1;
  int         m_phase = 0;
  logic [7:0] m_shd = '0;
  logic [7:0] sent[$];

  always #10 clk_i = ~clk_i;

  uart_txb_top u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .tx_en_i(tx_en_i), .bit_tick_i(bit_tick_i), .ready_o(ready_o), .load_o(load_o),
    .load_data_o(load_data_o), .shift_empty_o(shift_empty_o), .txd_o(txd_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic logic m_txd();
    if (m_phase == 0) return 1'b1;
    if (m_phase == 1) return 1'b0;
    if (m_phase <= 9) return m_shd[m_phase-2];
    return 1'b1;
  endfunction

  // one clock: drive, compare, advance model
  task automatic step(input logic wr, input logic [7:0] d, input logic en);
    logic m_load, acc, tick;
    @(negedge clk_i);
    tick       = (cyc % 4 == 0);
    wr_en_i    = wr;
    wr_data_i  = d;
    tx_en_i    = en;
    bit_tick_i = tick;
    #1;
    m_load = (m_q.size() > 0) && (m_phase == 0) && en;
    acc    = wr && m_ready && en;
    check("R2 R5", "ready_o", ready_o, m_ready);
    check("R4 R7", "load_o", load_o, m_load);
    if (m_load) check("R4 R3", "load_data_o", load_data_o, m_q[0]);
    check("R6", "shift_empty_o", shift_empty_o, m_phase == 0);
    check("R6", "txd_o", txd_o, m_txd());
    @(posedge clk_i);
    cyc++;
    if (acc) begin m_q.push_back(d); m_ready = 1'b0; end
    if (m_load) begin
      m_shd = m_q.pop_front(); sent.push_back(m_shd); m_phase = 1; m_ready = 1'b1;
    end else if (tick && m_phase > 0) begin
      m_phase = (m_phase == 10) ? 0 : m_phase + 1;
    end
  endtask

  task automatic idle(input int n, input logic en);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, en);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #35;
    // R1 reset state
    check("R1", "ready_o", ready_o, 1);
    check("R1", "load_o", load_o, 0);
    check("R1", "shift_empty_o", shift_empty_o, 1);
    check("R1", "txd_o", txd_o, 1);
    rst_ni = 1'b1;
    idle(3, 1'b1);
    // R2 single char, R6 frame
    step(1'b1, 8'hA5, 1'b1);
    idle(50, 1'b1);
    // R3 write while disabled is dropped
    step(1'b1, 8'h3C, 1'b0);
    idle(10, 1'b1);
    // R3 back-to-back: second write hits ready=0
    step(1'b1, 8'h81, 1'b1);
    step(1'b1, 8'hFF, 1'b1);
    idle(8, 1'b1);
    // R2 write during a frame waits in buffer
    step(1'b1, 8'h5A, 1'b1);
    step(1'b1, 8'h11, 1'b1);
    idle(50, 1'b1);
    idle(50, 1'b1);
    // R7 write then disable while busy: frame ends, next char held
    step(1'b1, 8'hC3, 1'b1);
    idle(3, 1'b1);
    step(1'b1, 8'h0F, 1'b1);
    idle(80, 1'b0);
    check("R7", "held shift_empty_o", shift_empty_o, 1);
    check("R7", "held ready_o", ready_o, 0);
    idle(60, 1'b1);
    // R3 dropped values never reach the line
    check("R3", "chars sent", sent.size(), 5);
    if (sent.size() == 5) begin
      check("R3", "char0", sent[0], 8'hA5);
      check("R3", "char1", sent[1], 8'h81);
      check("R3", "char2", sent[2], 8'h5A);
      check("R7", "char4", sent[4], 8'h0F);
    end
    // R8 covered by AST_NO_OVERFLOW; ready stays high when idle
    check("R8", "final ready_o", ready_o, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule